// File: doc/BRIEF.md
# Keyed-Clear Watchdog Timer

This block is the watchdog of a small microcontroller. A slow oscillator supplies a tick strobe, and the block counts those ticks. If software lets the count reach a fixed terminal value, the block raises a one-cycle overflow pulse. A downstream reset controller turns that pulse into a full system reset. Nothing can switch the watchdog off. It is armed again by every reset of the block.

Software restarts the count through a write-only service register on a byte-wide peripheral bus. The bus has an address, write data, a write strobe and a read strobe. Only one exact key byte written to one exact address counts as a service. Every other write is ignored. Reads of the service register return zero and leave the count alone.

After an overflow the block stops counting and waits, with the count held at zero, until its reset input is asserted. The terminal count is a parameter. The default is sized for an interval of roughly 0.175 s with a 32.768 kHz tick.

Top module: `kwdt_top`

## Requirements
- R1: While `rst_n` is low and right after it rises, `wdt_ovf` is low and the tick count is zero. Counting is armed with no other input.
- R2: A count of ticks is kept, where a tick is a clock edge with `tick` high. Take TERM_CNT as the terminal count. The TERM_CNT-th tick since the last restart makes `wdt_ovf` high in the clock cycle that follows the edge sampling that tick.
- R3: A service write restarts the count from zero at the edge where the strobe is sampled. A service write is `bus_wr` high with `bus_addr` = 0xCA and `bus_wdata` = 0x55. A service write takes priority over a tick at the same edge. The next overflow then needs TERM_CNT further ticks.
- R4: A write to 0xCA with any data other than 0x55 does not change the count or the time of the next overflow. Neither does a write of any data to any other address.
- R5: `wdt_ovf` is never high for two cycles in a row.
- R6: After an overflow, the count holds at zero. No further overflow occurs and service writes have no effect until `rst_n` is asserted.
- R7: `bus_rdata` is zero during every read. A read at any address does not change the count.
- R8: Clock cycles with `tick` low leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset; re-arms the watchdog |
| tick | input | 1 | One-cycle strobe from the slow oscillator time base |
| bus_addr | input | ADDR_W (8) | Peripheral bus address |
| bus_wdata | input | DATA_W (8) | Peripheral bus write data |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W (8) | Read data; always zero from this block |
| wdt_ovf | output | 1 | One-cycle overflow pulse to the reset controller |

## Verification
The count is visible only through the time at which `wdt_ovf` fires. A wrong internal count therefore shows up as an overflow that comes early, comes late, or never comes. It shows at the latest within TERM_CNT ticks of the fault.

A clear that is wrongly decoded has the same effect. It moves the overflow by the number of ticks counted before the write. A trip state that fails to hold shows up as a second pulse TERM_CNT ticks after the first.

The bench therefore replays a tick-accurate model alongside the block and compares the overflow output on every cycle. It sweeps every clear position, every wrong key byte and every wrong address on a small terminal count.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

   // Service register location and key on the peripheral bus
   localparam logic [7:0] KWDT_KEY_ADDR = 8'hCA;
   localparam logic [7:0] KWDT_KEY_VAL  = 8'h55;

   // Default terminal count: ~0.175 s of a 32.768 kHz tick
   localparam int unsigned KWDT_TERM_DEFAULT = 5734;

   typedef enum logic [0:0] {
      WD_ARMED   = 1'b0,
      WD_TRIPPED = 1'b1
   } wd_state_e;

endpackage

// File: rtl/kwdt_key_decode.sv
module kwdt_key_decode #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 8,
   parameter logic [7:0]  KEY_ADDR = kwdt_pkg::KWDT_KEY_ADDR,
   parameter logic [7:0]  KEY_VAL  = kwdt_pkg::KWDT_KEY_VAL
) (
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_wr,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              clr_hit
);

   localparam logic [ADDR_W-1:0] ADDR_MATCH = ADDR_W'(KEY_ADDR);
   localparam logic [DATA_W-1:0] DATA_MATCH = DATA_W'(KEY_VAL);

   logic addr_sel;
   logic key_ok;

   assign addr_sel = (bus_addr == ADDR_MATCH);
   assign key_ok   = (bus_wdata == DATA_MATCH);
   assign clr_hit  = bus_wr && addr_sel && key_ok;

   // The register is write-only: reads return zero at any address.
   assign bus_rdata = {DATA_W{1'b0}} & {DATA_W{bus_rd}};

endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
   parameter int unsigned TERM_CNT   = kwdt_pkg::KWDT_TERM_DEFAULT,
   parameter bit          COUNT_DOWN = 1'b0,
   localparam int unsigned CNT_W     = $clog2(TERM_CNT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             clr,
   input  logic             hold,
   output logic [CNT_W-1:0] elapsed,
   output logic             term_hit
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(TERM_CNT - 1);

   generate
      if (COUNT_DOWN) begin : g_down
         // Remaining ticks; terminal when the last one is consumed at zero.
         logic [CNT_W-1:0] remain_q;
         always_ff @(posedge clk) begin
            if (!rst_n || hold || clr) begin
               remain_q <= LAST;
            end else if (tick) begin
               remain_q <= (remain_q == '0) ? LAST : remain_q - 1'b1;
            end
         end
         assign term_hit = tick && !clr && !hold && (remain_q == '0);
         assign elapsed  = LAST - remain_q;
      end else begin : g_up
         // Ticks seen since restart; terminal on the tick after LAST.
         logic [CNT_W-1:0] count_q;
         always_ff @(posedge clk) begin
            if (!rst_n || hold || clr) begin
               count_q <= '0;
            end else if (tick) begin
               count_q <= (count_q == LAST) ? '0 : count_q + 1'b1;
            end
         end
         assign term_hit = tick && !clr && !hold && (count_q == LAST);
         assign elapsed  = count_q;
      end
   endgenerate

endmodule

// File: rtl/kwdt_trip.sv
module kwdt_trip (
   input  logic clk,
   input  logic rst_n,
   input  logic term_hit,
   output logic tripped,
   output logic wdt_ovf
);

   import kwdt_pkg::*;

   wd_state_e state_q;
   logic      ovf_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= WD_ARMED;
         ovf_q   <= 1'b0;
      end else begin
         ovf_q <= term_hit;
         if (term_hit) begin
            state_q <= WD_TRIPPED;
         end
      end
   end

   assign tripped = (state_q == WD_TRIPPED);
   assign wdt_ovf = ovf_q;

endmodule

// File: rtl/kwdt_top.sv
module kwdt_top #(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned TERM_CNT   = kwdt_pkg::KWDT_TERM_DEFAULT,
   parameter bit          COUNT_DOWN = 1'b0,
   localparam int unsigned CNT_W     = $clog2(TERM_CNT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_wr,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              wdt_ovf
);

   generate
      if (ADDR_W < 8) begin : g_bad_addr_w
         $error("kwdt_top: ADDR_W must be at least 8");
      end
      if (DATA_W < 8) begin : g_bad_data_w
         $error("kwdt_top: DATA_W must be at least 8");
      end
      if (TERM_CNT < 2) begin : g_bad_term
         $error("kwdt_top: TERM_CNT must be at least 2");
      end
   endgenerate

   logic             clr_hit;
   logic             tripped;
   logic             term_hit;
   logic [CNT_W-1:0] elapsed;

   kwdt_key_decode #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_decode (
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_rdata (bus_rdata),
      .clr_hit   (clr_hit)
   );

   kwdt_counter #(
      .TERM_CNT   (TERM_CNT),
      .COUNT_DOWN (COUNT_DOWN)
   ) u_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .clr      (clr_hit),
      .hold     (tripped),
      .elapsed  (elapsed),
      .term_hit (term_hit)
   );

   kwdt_trip u_trip (
      .clk      (clk),
      .rst_n    (rst_n),
      .term_hit (term_hit),
      .tripped  (tripped),
      .wdt_ovf  (wdt_ovf)
   );

endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk #(
   parameter int unsigned TERM_CNT = 2,
   parameter int unsigned CNT_W    = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             clr_hit,
   input logic             tripped,
   input logic [CNT_W-1:0] elapsed,
   input logic             wdt_ovf
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(TERM_CNT - 1);

   // R2: an untouched, armed tick advances the count by one
   p_count_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !clr_hit && !tripped && (elapsed < LAST))
      |=> (elapsed == CNT_W'($past(elapsed) + 1'b1)));

   // R2: overflow only follows a tick sampled at the last count
   p_ovf_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_ovf |-> ($past(tick) && ($past(elapsed) == LAST)));

   // R3: an armed service write restarts from zero and prevents overflow
   p_clear_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hit && !tripped) |=> ((elapsed == '0) && !wdt_ovf));

   // R5: the overflow pulse lasts a single cycle
   p_ovf_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_ovf |=> !wdt_ovf);

   // R6: once tripped, the count stays at zero and the state persists
   p_hold_tripped_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tripped |=> (tripped && (elapsed == '0)));

   // R8: no tick, no service write: the count is unchanged
   p_idle_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !clr_hit) |=> $stable(elapsed));

endmodule

bind kwdt_top kwdt_chk #(
   .TERM_CNT (TERM_CNT),
   .CNT_W    (CNT_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .tick    (tick),
   .clr_hit (clr_hit),
   .tripped (tripped),
   .elapsed (elapsed),
   .wdt_ovf (wdt_ovf)
);

// File: tb/kwdt_top_tb.sv
module kwdt_top_tb;

   localparam int CLK_PERIOD = 10;
   localparam int TERM       = 12;
   localparam int WD_CYCLES  = 200000;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       tick;
   logic [7:0] bus_addr;
   logic [7:0] bus_wdata;
   logic       bus_wr;
   logic       bus_rd;
   logic [7:0] bus_rdata;
   logic       wdt_ovf;

   int checks = 0;
   int errors = 0;

   // Reference model state, built from the requirements
   int m_cnt     = 0;
   bit m_tripped = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   kwdt_top #(
      .ADDR_W   (8),
      .DATA_W   (8),
      .TERM_CNT (TERM)
   ) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_rdata (bus_rdata),
      .wdt_ovf   (wdt_ovf)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // Drive one cycle at the falling edge, let the rising edge sample it,
   // then compare outputs at the next falling edge against the model.
   task automatic step(input string tag, input bit t, input bit wr, input bit rd,
                       input logic [7:0] a, input logic [7:0] d);
      bit exp_ovf;
      bit hit;
      tick      = t;
      bus_wr    = wr;
      bus_rd    = rd;
      bus_addr  = a;
      bus_wdata = d;
      #1;
      if (rd) check({tag, " rdata"}, bus_rdata, 8'h00);
      hit     = wr && (a == 8'hCA) && (d == 8'h55);
      exp_ovf = 1'b0;
      if (!m_tripped) begin
         if (hit) begin
            m_cnt = 0;
         end else if (t) begin
            if (m_cnt == TERM - 1) begin
               m_cnt     = 0;
               m_tripped = 1'b1;
               exp_ovf   = 1'b1;
            end else begin
               m_cnt++;
            end
         end
      end
      @(posedge clk);
      @(negedge clk);
      check({tag, " ovf"}, {7'b0, wdt_ovf}, {7'b0, exp_ovf});
      tick   = 1'b0;
      bus_wr = 1'b0;
      bus_rd = 1'b0;
   endtask

   task automatic ticks(input string tag, input int n);
      for (int i = 0; i < n; i++) step(tag, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      tick = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
      repeat (3) @(negedge clk);
      check("R1 ovf in reset", {7'b0, wdt_ovf}, 8'h00);
      rst_n = 1'b1;
      m_cnt = 0;
      m_tripped = 1'b0;
      @(negedge clk);
      check("R1 ovf after reset", {7'b0, wdt_ovf}, 8'h00);
   endtask

   initial begin
      #(CLK_PERIOD * WD_CYCLES);
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      // R1, R2, R5: straight timeout from reset
      do_reset();
      ticks("R2 timeout", TERM);
      step("R5 pulse end", 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);

      // R6: tripped holds through ticks and service writes
      ticks("R6 hold", 2 * TERM);
      step("R6 clear ignored", 1'b0, 1'b1, 1'b0, 8'hCA, 8'h55);
      ticks("R6 hold after clear", 2 * TERM);

      // R3: service at every position, then full interval
      for (int k = 0; k < TERM; k++) begin
         do_reset();
         ticks("R3 pre", k);
         step("R3 service", 1'b0, 1'b1, 1'b0, 8'hCA, 8'h55);
         ticks("R3 restart", TERM);
      end

      // R3: service colliding with the would-be terminal tick
      do_reset();
      ticks("R3 pre", TERM - 1);
      step("R3 service+tick", 1'b1, 1'b1, 1'b0, 8'hCA, 8'h55);
      ticks("R3 after collision", TERM);

      // R4: every wrong key byte to the service address
      do_reset();
      ticks("R4 pre", TERM - 1);
      for (int v = 0; v < 256; v++)
         if (v != 8'h55) step("R4 bad key", 1'b0, 1'b1, 1'b0, 8'hCA, 8'(v));
      ticks("R4 timeout kept", 1);

      // R4: the key byte to every other address
      do_reset();
      ticks("R4 pre", TERM - 1);
      for (int a = 0; a < 256; a++)
         if (a != 8'hCA) step("R4 bad addr", 1'b0, 1'b1, 1'b0, 8'(a), 8'h55);
      ticks("R4 timeout kept", 1);

      // R7: reads everywhere return zero and leave the count
      do_reset();
      ticks("R7 pre", TERM / 2);
      for (int a = 0; a < 256; a++)
         step("R7 read", 1'b0, 1'b0, 1'b1, 8'(a), 8'h55);
      step("R7 read+tick", 1'b1, 1'b0, 1'b1, 8'hCA, 8'h00);
      ticks("R7 timeout kept", TERM - TERM / 2 - 1);

      // R8: idle cycles do not advance
      do_reset();
      ticks("R8 pre", TERM - 1);
      for (int i = 0; i < 50; i++) step("R8 idle", 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
      ticks("R8 timeout", 1);

      // R1: reset re-arms after a trip
      do_reset();
      ticks("R1 rearmed", TERM);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule